// File: doc/BRIEF.md
# Four-Phase Handshake Pulse Synchronizer

This block carries single events from a source clock domain to a destination clock domain when the two clocks have no fixed relation. A rising edge on the source input sets a request flag. The flag holds as a level until the far side has seen it through a chain of metastability flip-flops and sent back an acknowledge. In the destination domain an edge detector on the synchronized request gives one output pulse per event.

The acknowledge travels back through its own flip-flop chain. The request clears only when the acknowledge arrives. The source then waits for the acknowledge to drop again before it accepts the next event. Each crossing therefore runs through all four phases: request up, acknowledge up, request down, acknowledge down. No event can be lost or doubled, whether the destination clock is faster or slower than the source clock.

While a handshake is in progress the source reports busy, and any new event during that time is discarded. The block carries no data with an event and does not queue events.

Top module: `hs_pulse_xing`

## Requirements
- R1: Once reset is released, busy_a and pulse_out are both 0, and pulse_out stays 0 until an event has been accepted.
- R2: An event is a rising edge of pulse_in, meaning pulse_in is 1 at a clk_a edge after being 0 at the previous edge. When busy_a is 0 the event is accepted, and busy_a reads 1 from the next clk_a edge.
- R3: After an event is accepted, the request stays set until the synchronized acknowledge is seen high in the source domain. busy_a stays 1 throughout, including the cycle in which pulse_out fires.
- R4: Each accepted event gives exactly one pulse_out, 1 for exactly one clk_b cycle. pulse_out never fires without an accepted event.
- R5: The request is cleared only after the synchronized acknowledge is high. It can be set again only after that acknowledge has returned low. busy_a returns to 0 once the acknowledge is low, and a new event is accepted after that.
- R6: A rising edge of pulse_in while busy_a is 1 is ignored and produces no pulse_out.
- R7: When pulse_in is held at 1 over many cycles, it counts as a single event, even after the handshake has finished.
- R8: No event is lost when clk_b is much faster than clk_a, when it is much slower, or when its period changes from one event to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Source domain clock |
| rst_a_n | input | 1 | Source domain reset, active low, asynchronous |
| pulse_in | input | 1 | Source event; its rising edge requests a crossing |
| busy_a | output | 1 | High while a handshake is in progress; events are ignored |
| clk_b | input | 1 | Destination domain clock |
| rst_b_n | input | 1 | Destination domain reset, active low, asynchronous |
| pulse_out | output | 1 | One clk_b cycle pulse per accepted event |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. This lengthens both synchronizer chains, which stretches the time a request is held and widens the window in which events arrive while the block is busy.

The source clock runs at a fixed 125 MHz. The destination clock runs at a fast ratio, then a slow ratio, then at a new random period for each event. This exercises both directions of the rate mismatch with the deeper chains.

// File: rtl/hs_xing_pkg.sv
`timescale 1ns/1ps
package hs_xing_pkg;

    // Source domain registered state
    typedef struct packed {
        logic req;       // held request level (set/reset flop)
        logic pin_prev;  // pulse_in from previous cycle, for edge detection
    } src_state_t;

    // Destination domain registered state
    typedef struct packed {
        logic seen;      // delayed copy of synchronized request, also the acknowledge
        logic pulse;     // registered single-cycle output pulse
    } dst_state_t;

    localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/hs_sync_chain.sv
`timescale 1ns/1ps
module hs_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    import hs_xing_pkg::*;

    localparam int N = (STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : STAGES;

    logic [N-1:0] chain_d;
    logic [N-1:0] chain_q;

    always_comb begin
        chain_d = {chain_q[N-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    // Only the last stage leaves the chain; it feeds a single consumer.
    assign q = chain_q[N-1];

endmodule

// File: rtl/hs_src_ctl.sv
`timescale 1ns/1ps
module hs_src_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    input  logic ack_seen,
    output logic req,
    output logic busy
);
    import hs_xing_pkg::*;

    src_state_t st_d;
    src_state_t st_q;
    logic       accept;

    always_comb begin
        st_d          = st_q;
        st_d.pin_prev = pulse_in;
        busy          = st_q.req | ack_seen;
        accept        = pulse_in & ~st_q.pin_prev & ~busy;
        if (accept) begin
            st_d.req = 1'b1;
        end else if (ack_seen) begin
            st_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;

endmodule

// File: rtl/hs_dst_ctl.sv
`timescale 1ns/1ps
module hs_dst_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_seen,
    output logic pulse,
    output logic ack
);
    import hs_xing_pkg::*;

    dst_state_t st_d;
    dst_state_t st_q;

    always_comb begin
        st_d       = st_q;
        st_d.seen  = req_seen;
        st_d.pulse = req_seen & ~st_q.seen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pulse;
    assign ack   = st_q.seen;

endmodule

// File: rtl/hs_pulse_xing.sv
`timescale 1ns/1ps
module hs_pulse_xing #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_a,
    input  logic rst_a_n,
    input  logic pulse_in,
    output logic busy_a,
    input  logic clk_b,
    input  logic rst_b_n,
    output logic pulse_out
);
    logic req_lvl;   // source domain request
    logic req_in_b;  // request after destination synchronizer
    logic ack_lvl;   // destination domain acknowledge
    logic ack_in_a;  // acknowledge after source synchronizer

    hs_src_ctl u_src (
        .clk      (clk_a),
        .rst_n    (rst_a_n),
        .pulse_in (pulse_in),
        .ack_seen (ack_in_a),
        .req      (req_lvl),
        .busy     (busy_a)
    );

    hs_sync_chain #(.STAGES(SYNC_STAGES)) u_sync_req (
        .clk   (clk_b),
        .rst_n (rst_b_n),
        .d     (req_lvl),
        .q     (req_in_b)
    );

    hs_dst_ctl u_dst (
        .clk      (clk_b),
        .rst_n    (rst_b_n),
        .req_seen (req_in_b),
        .pulse    (pulse_out),
        .ack      (ack_lvl)
    );

    hs_sync_chain #(.STAGES(SYNC_STAGES)) u_sync_ack (
        .clk   (clk_a),
        .rst_n (rst_a_n),
        .d     (ack_lvl),
        .q     (ack_in_a)
    );

endmodule

// File: rtl/hs_pulse_xing_chk.sv
`timescale 1ns/1ps
module hs_pulse_xing_chk (
    input logic clk_a,
    input logic rst_a_n,
    input logic pulse_in,
    input logic busy_a,
    input logic clk_b,
    input logic rst_b_n,
    input logic pulse_out,
    input logic req_lvl,
    input logic ack_in_a,
    input logic ack_lvl
);
    // R2: an accepted rising edge makes busy_a high on the next edge
    a_r2_busy_after_accept: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        ($rose(pulse_in) && !busy_a) |=> busy_a);

    // R3: request is held until the synchronized acknowledge is high
    a_r3_req_held: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (req_lvl && !ack_in_a) |=> req_lvl);

    // R5: request clears only after the acknowledge was seen high
    a_r5_clear_needs_ack: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        $fell(req_lvl) |-> $past(ack_in_a));

    // R5: a new request is never raised while the old acknowledge is still high
    a_r5_set_after_ack_low: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        $rose(req_lvl) |-> !$past(ack_in_a));

    // R6: a request is raised only from an idle source
    a_r6_no_set_when_busy: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        $rose(req_lvl) |-> !$past(busy_a));

    // R4: output pulse lasts a single destination cycle
    a_r4_pulse_single: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        pulse_out |=> !pulse_out);

    // R4: every output pulse coincides with a raised acknowledge
    a_r4_pulse_has_ack: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        pulse_out |-> ack_lvl);

endmodule

bind hs_pulse_xing hs_pulse_xing_chk u_chk (.*);

// File: tb/tb_hs_pulse_xing.sv
`timescale 1ns/1ps
module tb_hs_pulse_xing;
    localparam int STAGES = 3;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic rst_a_n = 1'b0;
    logic rst_b_n = 1'b0;
    logic pulse_in = 1'b0;
    logic busy_a;
    logic pulse_out;

    realtime half_b = 5.0;

    int checks = 0;
    int errors = 0;
    int expq[$];
    int next_id = 0;
    int pulses_seen = 0;
    bit prev_pulse = 1'b0;

    hs_pulse_xing #(.SYNC_STAGES(STAGES)) dut (
        .clk_a     (clk_a),
        .rst_a_n   (rst_a_n),
        .pulse_in  (pulse_in),
        .busy_a    (busy_a),
        .clk_b     (clk_b),
        .rst_b_n   (rst_b_n),
        .pulse_out (pulse_out)
    );

    always #4 clk_a = ~clk_a;          // 125 MHz source clock
    always #(half_b) clk_b = ~clk_b;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops one expected event per output pulse
    always @(negedge clk_b) begin
        if (rst_b_n) begin
            if (pulse_out) begin
                pulses_seen++;
                chk(!prev_pulse, "R4 pulse wider than one cycle", 2, 1);
                if (expq.size() == 0) begin
                    chk(1'b0, "R4 pulse_out without accepted event", 1, 0);
                end else begin
                    void'(expq.pop_front());
                    checks++;
                end
                chk(busy_a == 1'b1, "R3 busy_a during handshake", int'(busy_a), 1);
            end
            prev_pulse = pulse_out;
        end
    end

    // Driver: one accepted event, pushed to the scoreboard
    task automatic send_event();
        @(negedge clk_a);
        chk(busy_a == 1'b0, "R5 idle before new event", int'(busy_a), 0);
        pulse_in = 1'b1;
        expq.push_back(next_id);
        next_id++;
        @(negedge clk_a);
        pulse_in = 1'b0;
        chk(busy_a == 1'b1, "R2 busy_a after accept", int'(busy_a), 1);
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin
            @(negedge clk_a);
            n++;
        end while (busy_a && n < 5000);
        chk(busy_a == 1'b0, "R5 busy_a returns low", int'(busy_a), 0);
        repeat (4) @(negedge clk_b);
    endtask

    task automatic run_ratio(input realtime hb, input int n, input bit rnd, input string tag);
        for (int i = 0; i < n; i++) begin
            if (rnd) half_b = 1.5 + real'($urandom % 200) / 10.0;
            else     half_b = hb;
            send_event();
            wait_idle();
            if (expq.size() != 0)
                $display("FAIL R8 %s lost event actual=%0d expected=0", tag, expq.size());
            chk(expq.size() == 0, "R8 event delivered", expq.size(), 0);
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        // R1: reset state
        repeat (4) @(negedge clk_a);
        chk(busy_a == 1'b0, "R1 busy_a in reset", int'(busy_a), 0);
        chk(pulse_out == 1'b0, "R1 pulse_out in reset", int'(pulse_out), 0);
        rst_a_n = 1'b1;
        @(negedge clk_b);
        rst_b_n = 1'b1;
        repeat (30) @(negedge clk_b);
        chk(busy_a == 1'b0, "R1 busy_a after reset", int'(busy_a), 0);
        chk(pulses_seen == 0, "R1 no pulse after reset", pulses_seen, 0);

        // R8: fast destination, slow destination, random periods
        run_ratio(1.5, 10, 1'b0, "fast");
        run_ratio(29.0, 8, 1'b0, "slow");
        run_ratio(0.0, 20, 1'b1, "random");

        // R6: event during busy is ignored
        half_b = 13.0;
        base = pulses_seen;
        send_event();
        @(negedge clk_a);
        chk(busy_a == 1'b1, "R6 busy_a before second edge", int'(busy_a), 1);
        pulse_in = 1'b1;
        @(negedge clk_a);
        pulse_in = 1'b0;
        wait_idle();
        repeat (40) @(negedge clk_b);
        chk(pulses_seen - base == 1, "R6 ignored edge gave no pulse", pulses_seen - base, 1);

        // R7: held pulse_in counts once
        half_b = 2.5;
        base = pulses_seen;
        @(negedge clk_a);
        pulse_in = 1'b1;
        expq.push_back(next_id);
        next_id++;
        repeat (200) @(negedge clk_a);
        chk(busy_a == 1'b0, "R7 handshake done while held", int'(busy_a), 0);
        pulse_in = 1'b0;
        wait_idle();
        repeat (20) @(negedge clk_b);
        chk(pulses_seen - base == 1, "R7 held input one pulse", pulses_seen - base, 1);

        // R5: back-to-back events after completion
        run_ratio(7.0, 5, 1'b0, "back2back");
        chk(pulses_seen == next_id, "R4 total pulses", pulses_seen, next_id);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule